// File: doc/BRIEF.md
# Overflow-Aware Integer ALU

This block is the combinational integer execution unit of a small load-store processor. It takes two operands and a 4-bit operation code in the same cycle and returns a result word together with a zero flag and a signed-overflow flag. The operations are the four bitwise functions (AND, OR, NOR, XOR), addition and subtraction in signed and unsigned flavours, and signed and unsigned less-than comparison.

All arithmetic goes through one ripple-carry adder. Subtraction inverts every bit of the second operand and feeds a carry of one into the lowest stage, so A − B is formed as A + ~B + 1. The same adder provides both comparisons. Signed overflow is taken from the carries on either side of the top stage. The flag is raised only for the signed add and signed subtract codes, so the surrounding pipeline can route it to its trap logic. The unit has no clock and no state. Its outputs follow its inputs within the same cycle, and the instruction decoder that drives it applies no back-pressure.

Top module: `ovf_alu`

## Requirements
- R1: Opcodes 0010 (add) and 0011 (unsigned add) return (A + B) modulo 2^WIDTH.
- R2: Opcodes 0110 (subtract) and 0111 (unsigned subtract) return (A − B) modulo 2^WIDTH.
- R3: For opcode 0010, the overflow flag is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it. Operands of different sign never flag.
- R4: For opcode 0110, the overflow flag is 1 exactly when the operands' sign bits differ and the result's sign bit differs from A's. Operands of equal sign never flag.
- R5: The overflow flag is 0 for every opcode other than 0010 and 0110, including the unsigned add and subtract.
- R6: Opcodes 0000, 0001, 1100 and 1101 return A AND B, A OR B, NOT(A OR B) and A XOR B respectively.
- R7: Opcode 1000 returns 1 when A < B as two's-complement numbers and 0 otherwise, zero-extended to WIDTH bits. The answer stays correct when A − B itself overflows.
- R8: Opcode 1001 returns 1 when A < B as unsigned numbers and 0 otherwise, zero-extended to WIDTH bits.
- R9: The zero flag is 1 exactly when every result bit is 0, under every opcode.
- R10: Any opcode not listed above (0100, 0101, 1010, 1011, 1110, 1111) returns a zero result, a zero flag of 1 and an overflow flag of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH (32) | First operand |
| b_i | input | WIDTH (32) | Second operand |
| op_i | input | 4 | Operation code |
| result_o | output | WIDTH (32) | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow for signed add and subtract only |

## Verification
The bench targets the sign boundaries.

- It adds two large positives into the sign bit and two large negatives into zero. A design that compares operand signs in the wrong place, or taps the wrong carry, misses one of these flags.
- It subtracts across the sign boundary and compares the most negative value against a positive one. A less-than built from the difference sign alone then returns the inverted answer.
- It checks unsigned add and subtract at wrap-around. Leaking the overflow flag onto these opcodes would make them trap on legal code.
- It applies undefined opcodes with all-ones operands. Falling through to an arithmetic path would show a non-zero result or a stray flag.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_ADDU = 4'b0011,
    OP_SUB  = 4'b0110,
    OP_SUBU = 4'b0111,
    OP_SLT  = 4'b1000,
    OP_SLTU = 4'b1001,
    OP_NOR  = 4'b1100,
    OP_XOR  = 4'b1101
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_SUM,
    SEL_AND,
    SEL_OR,
    SEL_NOR,
    SEL_XOR,
    SEL_LTS,
    SEL_LTU
  } res_sel_e;

  typedef struct packed {
    logic     sub_mode;
    logic     ovf_en;
    res_sel_e sel;
  } alu_ctrl_t;

endpackage

// File: rtl/ovf_alu_decode.sv
module ovf_alu_decode
  import ovf_alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output alu_ctrl_t       ctrl
);

  always_comb begin
    ctrl = '{sub_mode: 1'b0, ovf_en: 1'b0, sel: SEL_ZERO};
    case (op)
      OP_AND:  ctrl.sel = SEL_AND;
      OP_OR:   ctrl.sel = SEL_OR;
      OP_NOR:  ctrl.sel = SEL_NOR;
      OP_XOR:  ctrl.sel = SEL_XOR;
      OP_ADD:  begin ctrl.sel = SEL_SUM; ctrl.ovf_en = 1'b1; end
      OP_ADDU: ctrl.sel = SEL_SUM;
      OP_SUB:  begin ctrl.sel = SEL_SUM; ctrl.sub_mode = 1'b1; ctrl.ovf_en = 1'b1; end
      OP_SUBU: begin ctrl.sel = SEL_SUM; ctrl.sub_mode = 1'b1; end
      OP_SLT:  begin ctrl.sel = SEL_LTS; ctrl.sub_mode = 1'b1; end
      OP_SLTU: begin ctrl.sel = SEL_LTU; ctrl.sub_mode = 1'b1; end
      default: ctrl = '{sub_mode: 1'b0, ovf_en: 1'b0, sel: SEL_ZERO};
    endcase
  end

endmodule

// File: rtl/ovf_alu_fa.sv
module ovf_alu_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);

  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (a & ci) | (b & ci);

endmodule

// File: rtl/ovf_alu_ripple.sv
module ovf_alu_ripple #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] sum,
  output logic             carry_msb_in,
  output logic             carry_out
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   carry;

  assign b_eff    = b ^ {WIDTH{sub_mode}};
  assign carry[0] = sub_mode;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    ovf_alu_fa u_fa (
      .a  (a[i]),
      .b  (b_eff[i]),
      .ci (carry[i]),
      .s  (sum[i]),
      .co (carry[i+1])
    );
  end

  assign carry_msb_in = carry[MSB];
  assign carry_out    = carry[WIDTH];

  logic [WIDTH:0] ref_total;
  always_comb begin
    ref_total = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_mode};
    // R1
    adder_sum_chk: assert ({carry_out, sum} == ref_total)
      else $error("ripple chain disagrees with arithmetic sum");
  end

endmodule

// File: rtl/ovf_alu_logic.sv
module ovf_alu_logic
  import ovf_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  res_sel_e         sel,
  output logic [WIDTH-1:0] out
);

  always_comb begin
    case (sel)
      SEL_AND: out = a & b;
      SEL_OR:  out = a | b;
      SEL_NOR: out = ~(a | b);
      SEL_XOR: out = a ^ b;
      default: out = '0;
    endcase
  end

endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
  import ovf_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] logic_out;
  logic             c_msb_in;
  logic             c_out;
  logic             raw_ovf;
  logic             lt_signed;
  logic             lt_unsigned;

  ovf_alu_decode u_decode (
    .op   (op_i),
    .ctrl (ctrl)
  );

  ovf_alu_ripple #(.WIDTH(WIDTH)) u_adder (
    .a            (a_i),
    .b            (b_i),
    .sub_mode     (ctrl.sub_mode),
    .sum          (sum),
    .carry_msb_in (c_msb_in),
    .carry_out    (c_out)
  );

  ovf_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a   (a_i),
    .b   (b_i),
    .sel (ctrl.sel),
    .out (logic_out)
  );

  assign raw_ovf     = c_msb_in ^ c_out;
  assign lt_signed   = sum[MSB] ^ raw_ovf;
  assign lt_unsigned = ~c_out;

  always_comb begin
    case (ctrl.sel)
      SEL_SUM: result_o = sum;
      SEL_LTS: result_o = {{(WIDTH-1){1'b0}}, lt_signed};
      SEL_LTU: result_o = {{(WIDTH-1){1'b0}}, lt_unsigned};
      SEL_AND, SEL_OR, SEL_NOR, SEL_XOR: result_o = logic_out;
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
  assign ovf_o  = ctrl.ovf_en & raw_ovf;

  always_comb begin
    // R3
    add_mixed_sign_chk: assert (!(op_i == OP_ADD && a_i[MSB] != b_i[MSB] && ovf_o))
      else $error("overflow flagged on add of mixed-sign operands");
    // R4
    sub_same_sign_chk: assert (!(op_i == OP_SUB && a_i[MSB] == b_i[MSB] && ovf_o))
      else $error("overflow flagged on subtract of same-sign operands");
    // R5
    no_overflow_chk: assert (!(op_i != OP_ADD && op_i != OP_SUB && ovf_o))
      else $error("overflow flagged on an opcode that never reports it");
    // R7
    slt_sign_chk: assert (!(op_i == OP_SLT && a_i[MSB] && !b_i[MSB]) || result_o == 1)
      else $error("negative A not reported below non-negative B");
    // R8
    sltu_width_chk: assert (!(op_i == OP_SLTU) || result_o[MSB:1] == '0)
      else $error("unsigned compare result not zero-extended");
    // R10
    unused_op_chk: assert (!(ctrl.sel == SEL_ZERO) || (result_o == '0 && zero_o && !ovf_o))
      else $error("undefined opcode produced activity");
  end

endmodule

// File: tb/ovf_alu_bench.sv
module ovf_alu_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a, b;
  logic [3:0]   op;
  logic [W-1:0] res;
  logic         zf, vf;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ovf_alu u_ovf_alu (
    .a_i      (a),
    .b_i      (b),
    .op_i     (op),
    .result_o (res),
    .zero_o   (zf),
    .ovf_o    (vf)
  );

  function automatic logic [W-1:0] exp_res(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    case (o)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b1100: return ~(x | y);
      4'b1101: return x ^ y;
      4'b0010, 4'b0011: return x + y;
      4'b0110, 4'b0111: return x - y;
      4'b1000: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b1001: return (x < y) ? 32'd1 : 32'd0;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] s;
    if (o == 4'b0010) begin
      s = x + y;
      return (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
    end
    if (o == 4'b0110) begin
      s = x - y;
      return (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
    end
    return 1'b0;
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'b0010: return "R3";
      4'b0011: return "R1";
      4'b0110: return "R4";
      4'b0111: return "R2";
      4'b1000: return "R7";
      4'b1001: return "R8";
      4'b0000, 4'b0001, 4'b1100, 4'b1101: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    logic [W-1:0] er;
    logic         ez, ev;
    @(negedge clk);
    op = o; a = x; b = y;
    er = exp_res(o, x, y);
    ez = (er == '0);
    ev = exp_ovf(o, x, y);
    @(posedge clk);
    #2;
    n_vec++;
    if (res !== er || zf !== ez || vf !== ev) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h got res=%h z=%b v=%b expected res=%h z=%b v=%b",
               tag, o, x, y, res, zf, vf, er, ez, ev);
    end
  endtask

  function automatic logic [W-1:0] pick_operand();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7fff_ffff;
      3: return 32'h8000_0000;
      4: return 32'hffff_ffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [3:0] codes [12];
    codes = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0110, 4'b0111,
              4'b1000, 4'b1001, 4'b1100, 4'b1101, 4'b0100, 4'b1111};
    void'($urandom(32'd20240));
    op = 4'b0000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle inputs: R9 zero flag on an all-zero AND
    apply(4'b0000, 32'h0, 32'h0, "R9");
    // R1
    apply(4'b0010, 32'd5, 32'd6, "R1");
    apply(4'b0011, 32'hffff_ffff, 32'h1, "R1/R5/R9");
    // R2
    apply(4'b0110, 32'd3, 32'd5, "R2");
    apply(4'b0111, 32'h0, 32'h1, "R2/R5");
    // R3
    apply(4'b0010, 32'h7fff_ffff, 32'h1, "R3");
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000, "R3/R9");
    apply(4'b0010, 32'h7fff_ffff, 32'h8000_0000, "R3");
    // R4
    apply(4'b0110, 32'h8000_0000, 32'h1, "R4");
    apply(4'b0110, 32'h7fff_ffff, 32'hffff_ffff, "R4");
    apply(4'b0110, 32'd5, 32'd5, "R4/R9");
    // R5
    apply(4'b0011, 32'h7fff_ffff, 32'h1, "R5");
    apply(4'b0111, 32'h8000_0000, 32'h1, "R5");
    // R6
    apply(4'b0000, 32'hf0f0_1234, 32'h0ff0_ffff, "R6");
    apply(4'b0001, 32'hf0f0_0000, 32'h000f_0f0f, "R6");
    apply(4'b1100, 32'hffff_ffff, 32'h0, "R6/R9");
    apply(4'b1100, 32'h0f0f_0f0f, 32'h0000_ffff, "R6");
    apply(4'b1101, 32'haaaa_5555, 32'hffff_0000, "R6");
    // R7
    apply(4'b1000, 32'h8000_0000, 32'h1, "R7");
    apply(4'b1000, 32'h7fff_ffff, 32'hffff_ffff, "R7");
    apply(4'b1000, 32'hffff_ffff, 32'h0, "R7");
    apply(4'b1000, 32'd9, 32'd9, "R7");
    // R8
    apply(4'b1001, 32'h0, 32'hffff_ffff, "R8");
    apply(4'b1001, 32'hffff_ffff, 32'h0, "R8");
    apply(4'b1001, 32'h1234, 32'h1234, "R8");
    // R10
    for (int k = 0; k < 16; k++) begin
      logic [3:0] c;
      c = 4'(k);
      if (c inside {4'b0100, 4'b0101, 4'b1010, 4'b1011, 4'b1110, 4'b1111})
        apply(c, 32'hffff_ffff, 32'hffff_ffff, "R10");
    end

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      c = codes[$urandom_range(0, 11)];
      apply(c, pick_operand(), pick_operand(), tag_of(c));
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule